// File: doc/BRIEF.md
# Single-Wire Slave Bit Interface

This block is the slave-side bit layer for a single open-drain data line on which every device can only pull low and a resistor pulls the line high. It runs from the system clock, oversamples a synchronized copy of the line, and converts the master's timed low pulses into events for the layer above: one strobe per data slot carrying the bit value, and one event per reset pulse. After each reset it answers with a presence pulse. In read slots it returns a 0 by holding the line low past the master's sample point, and it returns a 1 by leaving the line alone. It never drives the line high.

Two speeds are supported, standard and overdrive, chosen by a flag from the layer above. Each speed has its own sample point, reset threshold and presence timing. When a reset is seen, the block reports whether its length requires a return to standard speed. Reset pulses of 80 µs or less keep overdrive. Longer resets, including all of those in the 80–480 µs range, force standard speed. At standard speed, a falling edge that comes shortly after the line rises is treated as a glitch and ignored. All timing is expressed in microseconds and scaled by a clocks-per-microsecond parameter.

Top module: `ow_slave_phy`

## Requirements
- R1: While reset is asserted, and right after it is released, `pd_en`, `bit_stb` and `rst_seen` are all 0.
- R2: At standard speed (`od_mode`=0), each master low pulse produces exactly one `bit_stb` pulse, about 30 µs after the falling edge. `rx_bit` is 1 if the line is high at that point (lows of 1–15 µs) and 0 if it is low (lows of 60–120 µs).
- R3: At overdrive (`od_mode`=1) the sample point is 3 µs. Lows of 1–2 µs give 1, and lows of 6–16 µs give 0.
- R4: A slot that starts with `tx_en`=1 and `tx_bit`=0 asserts `pd_en` from the detected falling edge until the sample point. The line is therefore low 15 µs into the slot at standard speed and 2 µs into it at overdrive, and the slot's strobe reports 0.
- R5: A slot that starts with `tx_en`=1 and `tx_bit`=1 never asserts `pd_en`, and its strobe reports 1.
- R6: At standard speed, a low of at least 480 µs causes a single `rst_seen` pulse after the line returns high, with `rst_to_std`=1. A 300 µs low causes no reset event.
- R7: At overdrive, the reset threshold is 48 µs. A reset of 80 µs or less gives `rst_to_std`=0. A longer reset gives `rst_to_std`=1. A 40 µs low causes no reset event.
- R8: After `rst_seen`, `pd_en` rises after the presence wait time and stays high for the presence low time. These are 30 µs and 120 µs when the reset leaves the block at standard speed, and 3 µs and 12 µs when it stays in overdrive. The block's own presence low produces no strobe and no reset event.
- R9: At standard speed, a falling edge that arrives less than 2 µs after a rising edge is ignored and produces no strobe. One arriving later starts a slot. At overdrive there is no such window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw level of the shared data line |
| od_mode | input | 1 | 1 selects overdrive timing, 0 standard |
| tx_en | input | 1 | Next slot is a read slot answered by this slave |
| tx_bit | input | 1 | Bit to return in a read slot |
| pd_en | output | 1 | Active-high pull-down enable for the open-drain driver |
| bit_stb | output | 1 | One-cycle pulse at each slot's sample point |
| rx_bit | output | 1 | Line level sampled at the last strobe |
| rst_seen | output | 1 | One-cycle pulse when a reset pulse ends |
| rst_to_std | output | 1 | With the last reset: 1 if standard speed must be used |

## Verification
Each result falls due a fixed number of cycles after the stimulus. A strobe comes at the sample time plus about three cycles of synchronizer and edge pipeline after the pin falls. A reset event comes about three cycles after the line is released. The presence pull-down starts one presence wait time after that event and lasts exactly the presence low time. The bench checks strobe counts and values only after the whole slot, including recovery, has passed. It compares presence start and length, and read-slot drive length, against windows of a few cycles around the computed times. It samples the line level at the master's own sample instant to confirm the read-0 drive is still present.

// File: rtl/ow_phy_pkg.sv
package ow_phy_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SLOT    = 3'd1,
      ST_WAIT_HI = 3'd2,
      ST_PD_WAIT = 3'd3,
      ST_PD_LOW  = 3'd4
   } ow_state_e;

   function automatic int unsigned us_to_cyc(input int unsigned us, input int unsigned per_us);
      return us * per_us;
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ow_sync needs at least two stages");
   end

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/ow_edge_filter.sv
module ow_edge_filter #(
   parameter int unsigned REH_CYC    = 250,
   parameter bit          HOLDOFF_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_s,
   input  logic od_mode,
   output logic rise,
   output logic fall_any,
   output logic fall_ok
);
   localparam int unsigned HW = $clog2(REH_CYC + 1);

   logic line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b1;
      else        line_q <= line_s;
   end

   assign rise     = line_s & ~line_q;
   assign fall_any = ~line_s & line_q;

   if (HOLDOFF_EN) begin : g_holdoff
      localparam logic [HW-1:0] REH_K = HW'(REH_CYC);
      logic [HW-1:0] hcnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              hcnt <= REH_K;
         else if (rise)           hcnt <= '0;
         else if (hcnt != REH_K)  hcnt <= hcnt + HW'(1);
      end

      assign fall_ok = fall_any & (od_mode | (hcnt == REH_K));

      // R9: a falling edge right after a rise at standard speed is never a slot start
      p_holdoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (rise && !od_mode) |=> !fall_ok);
   end else begin : g_no_holdoff
      assign fall_ok = fall_any;
   end
endmodule

// File: rtl/ow_low_timer.sv
module ow_low_timer #(
   parameter int unsigned RST_STD_CYC = 60000,
   parameter int unsigned RST_OD_CYC  = 6000,
   parameter int unsigned KEEP_CYC    = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic line_s,
   input  logic fall_any,
   input  logic od_mode,
   output logic armed,
   output logic long_low
);
   localparam int unsigned   CW      = $clog2(RST_STD_CYC + 1);
   localparam logic [CW-1:0] MAX_K   = CW'(RST_STD_CYC);
   localparam logic [CW-1:0] OD_K    = CW'(RST_OD_CYC);
   localparam logic [CW-1:0] KEEP_K  = CW'(KEEP_CYC);

   if (RST_OD_CYC >= RST_STD_CYC || KEEP_CYC >= RST_STD_CYC) begin : g_bad_thr
      $error("ow_low_timer thresholds out of order");
   end

   logic [CW-1:0] lcnt;
   logic [CW-1:0] thr;

   assign thr = od_mode ? OD_K : MAX_K;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcnt  <= '0;
         armed <= 1'b0;
      end else if (!en) begin
         lcnt  <= '0;
         armed <= 1'b0;
      end else if (fall_any) begin
         lcnt  <= CW'(1);
         armed <= 1'b0;
      end else if (!line_s) begin
         if (lcnt != MAX_K) lcnt <= lcnt + CW'(1);
         if (lcnt >= thr)   armed <= 1'b1;
      end
   end

   assign long_low = (lcnt > KEEP_K);

   // R6: once a reset length is reached it stays recognised until the line rises
   p_arm_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !line_s && en && !fall_any) |=> armed);
endmodule

// File: rtl/ow_slave_phy.sv
module ow_slave_phy #(
   parameter int unsigned CLK_PER_US      = 125,
   parameter int unsigned SYNC_STAGES     = 2,
   parameter bit          HOLDOFF_EN      = 1'b1,
   parameter int unsigned T_SAMPLE_STD_US = 30,
   parameter int unsigned T_SAMPLE_OD_US  = 3,
   parameter int unsigned T_PDH_STD_US    = 30,
   parameter int unsigned T_PDH_OD_US     = 3,
   parameter int unsigned T_PDL_STD_US    = 120,
   parameter int unsigned T_PDL_OD_US     = 12,
   parameter int unsigned T_RST_STD_US    = 480,
   parameter int unsigned T_RST_OD_US     = 48,
   parameter int unsigned T_OD_KEEP_US    = 80,
   parameter int unsigned T_REH_US        = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic od_mode,
   input  logic tx_en,
   input  logic tx_bit,
   output logic pd_en,
   output logic bit_stb,
   output logic rx_bit,
   output logic rst_seen,
   output logic rst_to_std
);
   import ow_phy_pkg::*;

   localparam int unsigned SAMP_STD_C = us_to_cyc(T_SAMPLE_STD_US, CLK_PER_US);
   localparam int unsigned SAMP_OD_C  = us_to_cyc(T_SAMPLE_OD_US,  CLK_PER_US);
   localparam int unsigned PDH_STD_C  = us_to_cyc(T_PDH_STD_US,    CLK_PER_US);
   localparam int unsigned PDH_OD_C   = us_to_cyc(T_PDH_OD_US,     CLK_PER_US);
   localparam int unsigned PDL_STD_C  = us_to_cyc(T_PDL_STD_US,    CLK_PER_US);
   localparam int unsigned PDL_OD_C   = us_to_cyc(T_PDL_OD_US,     CLK_PER_US);
   localparam int unsigned RST_STD_C  = us_to_cyc(T_RST_STD_US,    CLK_PER_US);
   localparam int unsigned RST_OD_C   = us_to_cyc(T_RST_OD_US,     CLK_PER_US);
   localparam int unsigned KEEP_C     = us_to_cyc(T_OD_KEEP_US,    CLK_PER_US);
   localparam int unsigned REH_C      = us_to_cyc(T_REH_US,        CLK_PER_US);
   localparam int unsigned PMAX       = max3(SAMP_STD_C, PDH_STD_C, PDL_STD_C);
   localparam int unsigned PW         = $clog2(PMAX + 1);

   localparam logic [PW-1:0] SAMP_STD_K = PW'(SAMP_STD_C - 1);
   localparam logic [PW-1:0] SAMP_OD_K  = PW'(SAMP_OD_C - 1);
   localparam logic [PW-1:0] PDH_STD_K  = PW'(PDH_STD_C - 1);
   localparam logic [PW-1:0] PDH_OD_K   = PW'(PDH_OD_C - 1);
   localparam logic [PW-1:0] PDL_STD_K  = PW'(PDL_STD_C - 1);
   localparam logic [PW-1:0] PDL_OD_K   = PW'(PDL_OD_C - 1);

   if (CLK_PER_US < 2) begin : g_bad_clk
      $error("ow_slave_phy needs at least two clocks per microsecond");
   end
   if (SAMP_OD_C >= RST_OD_C || SAMP_STD_C >= RST_STD_C) begin : g_bad_samp
      $error("sample point must precede reset threshold");
   end
   if (HOLDOFF_EN && REH_C < 2) begin : g_bad_reh
      $error("hold-off window too short");
   end
   if (SAMP_OD_C < 1 || PDH_OD_C < 1 || PDL_OD_C < 1) begin : g_bad_zero
      $error("timing values must be non-zero");
   end

   logic line_s;
   logic rise, fall_any, fall_ok;
   logic armed, long_low, timer_en;

   ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (line_in),
      .q     (line_s)
   );

   ow_edge_filter #(.REH_CYC(REH_C), .HOLDOFF_EN(HOLDOFF_EN)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_s   (line_s),
      .od_mode  (od_mode),
      .rise     (rise),
      .fall_any (fall_any),
      .fall_ok  (fall_ok)
   );

   ow_low_timer #(.RST_STD_CYC(RST_STD_C), .RST_OD_CYC(RST_OD_C), .KEEP_CYC(KEEP_C)) u_low (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (timer_en),
      .line_s   (line_s),
      .fall_any (fall_any),
      .od_mode  (od_mode),
      .armed    (armed),
      .long_low (long_low)
   );

   ow_state_e     state;
   logic [PW-1:0] pcnt;
   logic          drv, stb, rxb, rseen, rstd, pd_od;
   logic [PW-1:0] samp_lim, pdh_lim, pdl_lim;

   assign timer_en = (state != ST_PD_WAIT) && (state != ST_PD_LOW);
   assign samp_lim = od_mode ? SAMP_OD_K : SAMP_STD_K;
   assign pdh_lim  = pd_od   ? PDH_OD_K  : PDH_STD_K;
   assign pdl_lim  = pd_od   ? PDL_OD_K  : PDL_STD_K;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         pcnt  <= '0;
         drv   <= 1'b0;
         stb   <= 1'b0;
         rxb   <= 1'b1;
         rseen <= 1'b0;
         rstd  <= 1'b1;
         pd_od <= 1'b0;
      end else begin
         stb   <= 1'b0;
         rseen <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (fall_ok) begin
                  state <= ST_SLOT;
                  pcnt  <= '0;
                  drv   <= tx_en & ~tx_bit;
               end else if (fall_any) begin
                  state <= ST_WAIT_HI;
               end
            end
            ST_SLOT: begin
               pcnt <= pcnt + PW'(1);
               if (pcnt == samp_lim) begin
                  stb   <= 1'b1;
                  rxb   <= line_s;
                  drv   <= 1'b0;
                  state <= line_s ? ST_IDLE : ST_WAIT_HI;
               end
            end
            ST_WAIT_HI: begin
               if (rise) begin
                  if (armed) begin
                     state <= ST_PD_WAIT;
                     pcnt  <= '0;
                     rseen <= 1'b1;
                     rstd  <= long_low | ~od_mode;
                     pd_od <= od_mode & ~long_low;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_PD_WAIT: begin
               pcnt <= pcnt + PW'(1);
               if (pcnt == pdh_lim) begin
                  state <= ST_PD_LOW;
                  pcnt  <= '0;
                  drv   <= 1'b1;
               end
            end
            ST_PD_LOW: begin
               pcnt <= pcnt + PW'(1);
               if (pcnt == pdl_lim) begin
                  drv   <= 1'b0;
                  state <= ST_IDLE;
               end
            end
            default: begin
               state <= ST_IDLE;
               drv   <= 1'b0;
            end
         endcase
      end
   end

   assign pd_en      = drv;
   assign bit_stb    = stb;
   assign rx_bit     = rxb;
   assign rst_seen   = rseen;
   assign rst_to_std = rstd;

   // R2: one strobe per slot, never two in a row
   p_stb_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |=> !bit_stb);

   // R6: the reset event is a single-cycle pulse
   p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_seen |=> !rst_seen);

   // R5: a slot drive only starts when a 0 was requested for transmission
   p_tx_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pd_en) && state == ST_SLOT) |-> $past(tx_en && !tx_bit));

   // R8: presence low always follows the presence wait
   p_pd_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pd_en) && state == ST_PD_LOW) |-> ($past(state) == ST_PD_WAIT));

   // R8: no strobe while answering a reset
   p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PD_WAIT || state == ST_PD_LOW) |-> !bit_stb);

   // R4: pull-down only in a read slot or a presence pulse
   p_drive_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pd_en |-> (state == ST_SLOT || state == ST_PD_LOW));
endmodule

// File: tb/ow_slave_phy_test.sv
`timescale 1ns/1ps
module ow_slave_phy_test;
   localparam int U = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_low = 1'b0;
   logic od_mode = 1'b0;
   logic tx_en = 1'b0;
   logic tx_bit = 1'b0;
   logic pd_en, bit_stb, rx_bit, rst_seen, rst_to_std;
   logic ow_line;

   assign ow_line = ~(m_low | pd_en);

   always #4 clk = ~clk;

   ow_slave_phy #(.CLK_PER_US(U)) uut (
      .clk(clk), .rst_n(rst_n), .line_in(ow_line), .od_mode(od_mode),
      .tx_en(tx_en), .tx_bit(tx_bit), .pd_en(pd_en), .bit_stb(bit_stb),
      .rx_bit(rx_bit), .rst_seen(rst_seen), .rst_to_std(rst_to_std)
   );

   int n_chk = 0;
   int n_err = 0;

   int cyc = 0, n_stb = 0, n_rst = 0, n_pd_runs = 0;
   int pd_rise_cyc = 0, pd_run = 0, run_cnt = 0;
   logic last_rx = 1'b1, last_std = 1'b1, pd_prev = 1'b0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (bit_stb)  begin n_stb = n_stb + 1; last_rx = rx_bit; end
      if (rst_seen) begin n_rst = n_rst + 1; last_std = rst_to_std; end
      if (pd_en && !pd_prev) pd_rise_cyc = cyc;
      if (pd_en) run_cnt = run_cnt + 1;
      else if (run_cnt != 0) begin pd_run = run_cnt; n_pd_runs = n_pd_runs + 1; run_cnt = 0; end
      pd_prev = pd_en;
   end

   function automatic int samp_us(input bit od);
      return od ? 3 : 30;
   endfunction

   function automatic bit exp_rx(input int low_us, input bit od);
      return (low_us < samp_us(od)) ? 1'b1 : 1'b0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_err = n_err + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_us(input int us);
      wait_cyc(us * U);
   endtask

   task automatic slot(input int low_us, input int total_us);
      @(negedge clk);
      m_low = 1'b1;
      wait_us(low_us);
      m_low = 1'b0;
      wait_us(total_us - low_us);
   endtask

   task automatic write_check(input int low_us, input int total_us, input string req);
      int s;
      bit e;
      s = n_stb;
      e = exp_rx(low_us, od_mode);
      slot(low_us, total_us);
      check((n_stb - s) == 1 && last_rx == e, req, (n_stb - s) * 10 + int'(last_rx), 10 + int'(e));
   endtask

   // reset of low_us; checks event, speed result and presence timing
   task automatic reset_check(input int low_us, input bit exp_std, input string req);
      int sr, ss, sp, t_rel, pdh, pdl;
      sr = n_rst; ss = n_stb; sp = n_pd_runs;
      pdh = exp_std ? 30 * U : 3 * U;
      pdl = exp_std ? 120 * U : 12 * U;
      @(negedge clk);
      m_low = 1'b1;
      wait_us(low_us);
      m_low = 1'b0;
      t_rel = cyc;
      wait_us(200);
      check((n_rst - sr) == 1, req, n_rst - sr, 1);
      check(last_std == exp_std, req, int'(last_std), int'(exp_std));
      // R8: presence start and length
      check((pd_rise_cyc - t_rel) >= pdh && (pd_rise_cyc - t_rel) <= pdh + 6, "R8", pd_rise_cyc - t_rel, pdh + 3);
      check(pd_run >= pdl - 1 && pd_run <= pdl + 1 && (n_pd_runs - sp) == 1, "R8", pd_run, pdl);
      check((n_stb - ss) == 1 && (n_rst - sr) == 1, "R8", n_stb - ss, 1);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
      $finish;
   end

   initial begin : main
      int s, sp, sr, t0;
      void'($urandom(32'd20240611));
      wait_cyc(5);
      // R1: reset state
      check(pd_en == 1'b0 && bit_stb == 1'b0 && rst_seen == 1'b0, "R1",
            int'({pd_en, bit_stb, rst_seen}), 0);
      rst_n = 1'b1;
      wait_cyc(2);
      check(pd_en == 1'b0 && bit_stb == 1'b0 && rst_seen == 1'b0, "R1",
            int'({pd_en, bit_stb, rst_seen}), 0);
      wait_us(10);

      // R2: standard write slots
      write_check(6, 70, "R2");
      write_check(80, 90, "R2");
      write_check(15, 70, "R2");
      write_check(60, 70, "R2");

      // R3: overdrive write slots
      od_mode = 1'b1;
      wait_us(5);
      write_check(1, 9, "R3");
      write_check(2, 9, "R3");
      write_check(8, 11, "R3");
      write_check(16, 19, "R3");

      // R4: read-0 at standard speed
      od_mode = 1'b0;
      wait_us(10);
      tx_en = 1'b1; tx_bit = 1'b0;
      s = n_stb; sp = n_pd_runs;
      @(negedge clk);
      m_low = 1'b1;
      wait_us(2);
      m_low = 1'b0;
      wait_us(13);
      check(ow_line == 1'b0, "R4", int'(ow_line), 0);
      wait_us(55);
      check((n_stb - s) == 1 && last_rx == 1'b0, "R4", int'(last_rx), 0);
      check((n_pd_runs - sp) == 1 && pd_run >= 30 * U - 2 && pd_run <= 30 * U + 2, "R4", pd_run, 30 * U);

      // R4: read-0 at overdrive
      od_mode = 1'b1;
      wait_us(5);
      s = n_stb;
      @(negedge clk);
      m_low = 1'b1;
      wait_us(1);
      m_low = 1'b0;
      wait_us(1);
      check(ow_line == 1'b0, "R4", int'(ow_line), 0);
      wait_us(8);
      check((n_stb - s) == 1 && last_rx == 1'b0, "R4", int'(last_rx), 0);

      // R5: read-1 never drives
      od_mode = 1'b0;
      wait_us(10);
      tx_bit = 1'b1;
      s = n_stb; sp = n_pd_runs;
      slot(2, 70);
      check((n_pd_runs - sp) == 0, "R5", n_pd_runs - sp, 0);
      check((n_stb - s) == 1 && last_rx == 1'b1, "R5", int'(last_rx), 1);
      tx_en = 1'b0;

      // R6: standard reset and a sub-threshold low
      wait_us(10);
      reset_check(500, 1'b1, "R6");
      sr = n_rst; s = n_stb;
      slot(300, 320);
      check((n_rst - sr) == 0, "R6", n_rst - sr, 0);
      check((n_stb - s) == 1 && last_rx == 1'b0, "R6", int'(last_rx), 0);

      // R7: overdrive resets
      od_mode = 1'b1;
      wait_us(10);
      reset_check(60, 1'b0, "R7");
      sr = n_rst;
      slot(40, 50);
      check((n_rst - sr) == 0, "R7", n_rst - sr, 0);
      reset_check(200, 1'b1, "R7");
      od_mode = 1'b0;
      wait_us(10);

      // R9: glitch inside the standard hold-off window
      s = n_stb;
      @(negedge clk);
      m_low = 1'b1; wait_us(80); m_low = 1'b0;
      wait_cyc(U);
      m_low = 1'b1; wait_cyc(2 * U); m_low = 1'b0;
      wait_us(60);
      check((n_stb - s) == 1 && last_rx == 1'b0, "R9", n_stb - s, 1);
      // R9: edge after the window starts a slot
      s = n_stb;
      @(negedge clk);
      m_low = 1'b1; wait_us(80); m_low = 1'b0;
      wait_us(4);
      m_low = 1'b1; wait_us(2); m_low = 1'b0;
      wait_us(70);
      check((n_stb - s) == 2 && last_rx == 1'b1, "R9", n_stb - s, 2);
      // R9: no window at overdrive
      od_mode = 1'b1;
      wait_us(5);
      s = n_stb;
      @(negedge clk);
      m_low = 1'b1; wait_us(8); m_low = 1'b0;
      wait_us(1);
      m_low = 1'b1; wait_us(1); m_low = 1'b0;
      wait_us(10);
      check((n_stb - s) == 2 && last_rx == 1'b1, "R9", n_stb - s, 2);

      // R2/R3: constrained random write slots
      for (int i = 0; i < 40; i++) begin
         bit odr, b;
         int lo, tot;
         odr = 1'($urandom_range(0, 1));
         b   = 1'($urandom_range(0, 1));
         od_mode = odr;
         wait_us(5);
         if (odr) begin
            lo  = b ? int'($urandom_range(1, 2)) : int'($urandom_range(6, 16));
            tot = ((lo < 5) ? 5 : lo) + int'($urandom_range(2, 4));
            write_check(lo, tot, "R3");
         end else begin
            lo  = b ? int'($urandom_range(1, 15)) : int'($urandom_range(60, 120));
            tot = ((lo < 35) ? 35 : lo) + int'($urandom_range(5, 10));
            write_check(lo, tot, "R2");
         end
      end

      t0 = cyc;
      wait_cyc(10);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule